// File: doc/BRIEF.md
# Adaptive Traffic Phase Switch Controller

This block decides when the signal at a two-arm crossing should leave its current phase. It keeps a queue count for each arm. Cars arriving over an entry sensor raise the count and cars leaving over an exit sensor lower it. A phase timer advances on a slow time tick. The controller weighs each arm's queue against the other through a small integer control function, f = alpha * n_own + beta - n_other. It then issues a single-cycle switch request when the rules for the present phase kind are met.

The surrounding sequencer owns the lamps. It supplies the current phase kind and which arm the phase serves. It reacts to the switch request by moving to its next phase. All limits and weights are static configuration inputs. Minimum and maximum durations are given per arm for green, as one pair for the red-plus-left phase, and as a single limit for the pedestrian phase.

Top module: `traffic_phase_ctl`

## Requirements
- R1: Each arm has its own queue count. An entry pulse alone adds one and an exit pulse alone removes one, with no effect on the other arm. Counts change on the clock edge at which the pulse is sampled and reset to 0.
- R2: A count never wraps. An exit pulse at 0 leaves it at 0, and an entry pulse at 2^CNT_W-1 (63 by default) leaves it there.
- R3: When an entry pulse and an exit pulse arrive for the same arm in the same cycle, that arm's count does not change.
- R4: The phase timer T gains one on each clock edge at which tick is high. In a green phase (phase_kind = 0), no switch is requested while T is below the favoured arm's minimum. That minimum is min_a when favour_b = 0 and min_b when favour_b = 1.
- R5: In a green phase, a switch is forced once T reaches the favoured arm's maximum (max_a or max_b). switch_req rises on the clock edge after the edge that made the condition true.
- R6: In a green phase with T between the minimum and the maximum, a switch is requested when the favoured arm's count is 0 or when its f is at or below zero. Here f = alpha * n_favoured + beta - n_other. alpha is unsigned and beta is a two's-complement value of COEF_W bits.
- R7: In a green or red-plus-left phase with T at or above the minimum, a switch is requested once the favoured arm's count has stayed unchanged for STALL_TICKS ticks (5 by default).
- R8: A red-plus-left phase (phase_kind = 1) uses min_left and max_left in place of the per-arm limits. Between them it switches when the favoured count is 0 or the traffic has stalled. The control function is not used in this phase.
- R9: A pedestrian phase (phase_kind = 2) requests a switch when T is at or above max_ped, whatever the counts.
- R10: switch_req is high for exactly one cycle. On the same clock edge T and the stall measure are cleared, so the next request again needs the phase's minimum time to elapse.
- R11: With phase_kind = 3 (idle), no switch is ever requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_a | input | 1 | Entry sensor pulse, arm A |
| leave_a | input | 1 | Exit sensor pulse, arm A |
| enter_b | input | 1 | Entry sensor pulse, arm B |
| leave_b | input | 1 | Exit sensor pulse, arm B |
| tick | input | 1 | One-cycle time unit strobe |
| phase_kind | input | 2 | 0 green, 1 red-plus-left, 2 pedestrian, 3 idle |
| favour_b | input | 1 | 0: phase serves arm A, 1: arm B |
| alpha_a | input | COEF_W | Queue weight, arm A (unsigned) |
| beta_a | input | COEF_W | Offset, arm A (two's complement) |
| alpha_b | input | COEF_W | Queue weight, arm B (unsigned) |
| beta_b | input | COEF_W | Offset, arm B (two's complement) |
| min_a | input | TIME_W | Minimum green time, arm A |
| max_a | input | TIME_W | Maximum green time, arm A |
| min_b | input | TIME_W | Minimum green time, arm B |
| max_b | input | TIME_W | Maximum green time, arm B |
| min_left | input | TIME_W | Minimum red-plus-left time |
| max_left | input | TIME_W | Maximum red-plus-left time |
| max_ped | input | TIME_W | Pedestrian phase length |
| switch_req | output | 1 | One-cycle request to leave the phase |
| count_a | output | CNT_W | Queue count, arm A |
| count_b | output | CNT_W | Queue count, arm B |

## Verification
On every cycle, the assertions check these local rules: the single-cycle shape of the request, the clearing of the timer with it, the unit step and floor of the counts, the cancellation of simultaneous pulses, the green minimum and the pedestrian limit at the moment of a request, and the silence of the idle phase. Only the bench scenarios can show whether a request comes at the right tick. That covers the forced switch at the maximum, the control function crossing zero as the opposite queue grows, the stall rule after five quiet ticks, the separate left-turn limits, and repeated requests once the timer has been cleared. Those cases need a history of pulses and ticks to build the condition.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   typedef enum logic [1:0] {
      PH_GREEN = 2'd0,
      PH_LEFT  = 2'd1,
      PH_PED   = 2'd2,
      PH_IDLE  = 2'd3
   } phase_e;

   // Number of bits needed to hold the weighted control function.
   function automatic int fn_width(input int cnt_w, input int coef_w);
      return cnt_w + coef_w + 2;
   endfunction
endpackage

// File: rtl/tpc_queue_counter.sv
module tpc_queue_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_d;

   always_comb begin
      count_d = count_q;
      if (inc && !dec && count_q != CNT_TOP)
         count_d = count_q + CNT_W'(1);
      else if (dec && !inc && count_q != '0)
         count_d = count_q - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end

   assign count = count_q;
endmodule

// File: rtl/tpc_ctrl_fn.sv
module tpc_ctrl_fn #(
   parameter int CNT_W  = 6,
   parameter int COEF_W = 4
) (
   input  logic [COEF_W-1:0] alpha,
   input  logic [COEF_W-1:0] beta,
   input  logic [CNT_W-1:0]  n_own,
   input  logic [CNT_W-1:0]  n_other,
   output logic              not_positive
);
   localparam int F_W = tpc_pkg::fn_width(CNT_W, COEF_W);

   logic [F_W-1:0] prod;
   logic [F_W-1:0] beta_x;
   logic [F_W-1:0] f_val;

   assign prod   = F_W'(alpha) * F_W'(n_own);
   assign beta_x = {{(F_W-COEF_W){beta[COEF_W-1]}}, beta};
   assign f_val  = prod + beta_x - F_W'(n_other);
   assign not_positive = f_val[F_W-1] || (f_val == '0);
endmodule

// File: rtl/tpc_phase_timer.sv
module tpc_phase_timer #(
   parameter int TIME_W      = 6,
   parameter int CNT_W       = 6,
   parameter int STALL_TICKS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              clear,
   input  logic [CNT_W-1:0]  fav_count,
   output logic [TIME_W-1:0] phase_time,
   output logic              stalled
);
   localparam int STALL_W = $clog2(STALL_TICKS + 1);
   localparam logic [TIME_W-1:0]  T_TOP     = '1;
   localparam logic [STALL_W-1:0] STALL_LIM = STALL_W'(STALL_TICKS);

   logic [TIME_W-1:0]  t_q;
   logic [STALL_W-1:0] quiet_q;
   logic [CNT_W-1:0]   last_cnt_q;
   logic               moved;

   assign moved = (fav_count != last_cnt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q        <= '0;
         quiet_q    <= '0;
         last_cnt_q <= '0;
      end else begin
         last_cnt_q <= fav_count;
         if (clear)
            t_q <= '0;
         else if (tick && t_q != T_TOP)
            t_q <= t_q + TIME_W'(1);
         if (clear || moved)
            quiet_q <= '0;
         else if (tick && quiet_q != STALL_LIM)
            quiet_q <= quiet_q + STALL_W'(1);
      end
   end

   assign phase_time = t_q;
   assign stalled    = (quiet_q == STALL_LIM);
endmodule

// File: rtl/traffic_phase_ctl.sv
module traffic_phase_ctl #(
   parameter int CNT_W       = 6,
   parameter int TIME_W      = 6,
   parameter int COEF_W      = 4,
   parameter int STALL_TICKS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_a,
   input  logic              leave_a,
   input  logic              enter_b,
   input  logic              leave_b,
   input  logic              tick,
   input  logic [1:0]        phase_kind,
   input  logic              favour_b,
   input  logic [COEF_W-1:0] alpha_a,
   input  logic [COEF_W-1:0] beta_a,
   input  logic [COEF_W-1:0] alpha_b,
   input  logic [COEF_W-1:0] beta_b,
   input  logic [TIME_W-1:0] min_a,
   input  logic [TIME_W-1:0] max_a,
   input  logic [TIME_W-1:0] min_b,
   input  logic [TIME_W-1:0] max_b,
   input  logic [TIME_W-1:0] min_left,
   input  logic [TIME_W-1:0] max_left,
   input  logic [TIME_W-1:0] max_ped,
   output logic              switch_req,
   output logic [CNT_W-1:0]  count_a,
   output logic [CNT_W-1:0]  count_b
);
   import tpc_pkg::*;

   localparam int ARMS = 2;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("traffic_phase_ctl: CNT_W out of range");
   end
   if (COEF_W < 2 || TIME_W < 3) begin : g_bad_w
      $error("traffic_phase_ctl: COEF_W or TIME_W too small");
   end
   if (STALL_TICKS < 1) begin : g_bad_stall
      $error("traffic_phase_ctl: STALL_TICKS must be positive");
   end

   logic [CNT_W-1:0]  cnt     [ARMS];
   logic              inc_v   [ARMS];
   logic              dec_v   [ARMS];
   logic [COEF_W-1:0] alpha_v [ARMS];
   logic [COEF_W-1:0] beta_v  [ARMS];
   logic              f_le0   [ARMS];

   assign inc_v[0]   = enter_a;
   assign dec_v[0]   = leave_a;
   assign inc_v[1]   = enter_b;
   assign dec_v[1]   = leave_b;
   assign alpha_v[0] = alpha_a;
   assign beta_v[0]  = beta_a;
   assign alpha_v[1] = alpha_b;
   assign beta_v[1]  = beta_b;

   for (genvar g = 0; g < ARMS; g++) begin : g_arm
      tpc_queue_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc_v[g]),
         .dec   (dec_v[g]),
         .count (cnt[g])
      );
      tpc_ctrl_fn #(.CNT_W(CNT_W), .COEF_W(COEF_W)) u_fn (
         .alpha        (alpha_v[g]),
         .beta         (beta_v[g]),
         .n_own        (cnt[g]),
         .n_other      (cnt[ARMS-1-g]),
         .not_positive (f_le0[g])
      );
   end

   logic [CNT_W-1:0]  fav_cnt;
   logic              fav_le0;
   logic [TIME_W-1:0] green_min;
   logic [TIME_W-1:0] green_max;
   logic [TIME_W-1:0] phase_time;
   logic              stalled;
   logic              want;
   logic              fire;
   logic              switch_q;
   phase_e            kind;

   assign kind      = phase_e'(phase_kind);
   assign fav_cnt   = favour_b ? cnt[1]   : cnt[0];
   assign fav_le0   = favour_b ? f_le0[1] : f_le0[0];
   assign green_min = favour_b ? min_b    : min_a;
   assign green_max = favour_b ? max_b    : max_a;

   always_comb begin
      want = 1'b0;
      unique case (kind)
         PH_GREEN: want = (phase_time >= green_max) ||
                          ((phase_time >= green_min) &&
                           (fav_cnt == '0 || fav_le0 || stalled));
         PH_LEFT:  want = (phase_time >= max_left) ||
                          ((phase_time >= min_left) &&
                           (fav_cnt == '0 || stalled));
         PH_PED:   want = (phase_time >= max_ped);
         PH_IDLE:  want = 1'b0;
      endcase
   end

   assign fire = want && !switch_q;

   tpc_phase_timer #(
      .TIME_W      (TIME_W),
      .CNT_W       (CNT_W),
      .STALL_TICKS (STALL_TICKS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .clear      (fire),
      .fav_count  (fav_cnt),
      .phase_time (phase_time),
      .stalled    (stalled)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) switch_q <= 1'b0;
      else        switch_q <= fire;
   end

   assign switch_req = switch_q;
   assign count_a    = cnt[0];
   assign count_b    = cnt[1];
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
   parameter int CNT_W  = 6,
   parameter int TIME_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enter_a,
   input logic              leave_a,
   input logic [CNT_W-1:0]  count_a,
   input logic              switch_req,
   input logic [1:0]        phase_kind,
   input logic              favour_b,
   input logic [TIME_W-1:0] min_a,
   input logic [TIME_W-1:0] max_ped,
   input logic [TIME_W-1:0] phase_time
);
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      switch_req |=> !switch_req); // R10

   AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      switch_req |-> phase_time == '0); // R10

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count_a) |-> (count_a == $past(count_a) + CNT_W'(1)) ||
                            (count_a == $past(count_a) - CNT_W'(1))); // R1

   AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (count_a == '0 && !enter_a) |=> count_a == '0); // R2

   AST_BOTH_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_a && leave_a) |=> $stable(count_a)); // R3

   AST_GREEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(switch_req) && $past(phase_kind) == 2'd0 && !$past(favour_b))
      |-> $past(phase_time) >= $past(min_a)); // R4

   AST_PED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(switch_req) && $past(phase_kind) == 2'd2)
      |-> $past(phase_time) >= $past(max_ped)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_kind == 2'd3) |=> !switch_req); // R11
endmodule

bind traffic_phase_ctl tpc_checker #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enter_a    (enter_a),
   .leave_a    (leave_a),
   .count_a    (count_a),
   .switch_req (switch_req),
   .phase_kind (phase_kind),
   .favour_b   (favour_b),
   .min_a      (min_a),
   .max_ped    (max_ped),
   .phase_time (phase_time)
);

// File: tb/traffic_phase_ctl_test.sv
module traffic_phase_ctl_test;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 6;
   localparam int TIME_W = 6;
   localparam int COEF_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enter_a = 0, leave_a = 0, enter_b = 0, leave_b = 0, tick = 0;
   logic [1:0] phase_kind = 2'd3;
   logic favour_b = 1'b0;
   logic [COEF_W-1:0] alpha_a = 4'd2, beta_a = 4'd1, alpha_b = 4'd1, beta_b = 4'd0;
   logic [TIME_W-1:0] min_a = 6'd3, max_a = 6'd10, min_b = 6'd2, max_b = 6'd8;
   logic [TIME_W-1:0] min_left = 6'd2, max_left = 6'd6, max_ped = 6'd4;
   logic switch_req;
   logic [CNT_W-1:0] count_a, count_b;

   int checks = 0;
   int errors = 0;
   int ticks_given = 0;
   bit done = 0;

   typedef struct {
      string req;
      int    ticks;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   traffic_phase_ctl #(.CNT_W(CNT_W), .TIME_W(TIME_W), .COEF_W(COEF_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .enter_a(enter_a), .leave_a(leave_a), .enter_b(enter_b), .leave_b(leave_b),
      .tick(tick), .phase_kind(phase_kind), .favour_b(favour_b),
      .alpha_a(alpha_a), .beta_a(beta_a), .alpha_b(alpha_b), .beta_b(beta_b),
      .min_a(min_a), .max_a(max_a), .min_b(min_b), .max_b(max_b),
      .min_left(min_left), .max_left(max_left), .max_ped(max_ped),
      .switch_req(switch_req), .count_a(count_a), .count_b(count_b)
   );

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", r, act, exp);
      end
   endtask

   // Driver side of the scoreboard: a switch is expected after this many ticks.
   task automatic expect_sw(input string r, input int t);
      exp_t e;
      e.req = r;
      e.ticks = t;
      sb_q.push_back(e);
   endtask

   // Monitor: each request pops one expectation and compares the tick count.
   always @(negedge clk) begin
      if (rst_n && switch_req) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected switch actual ticks %0d expected none", ticks_given);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.ticks != ticks_given) begin
               errors++;
               $display("FAIL %s switch actual ticks %0d expected %0d",
                        e.req, ticks_given, e.ticks);
            end
         end
      end
   end

   task automatic restart(input logic [1:0] ph, input logic fb);
      @(negedge clk);
      rst_n = 1'b0;
      phase_kind = 2'd3;
      favour_b = fb;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      ticks_given = 0;
      phase_kind = ph;
   endtask

   task automatic pulse(input logic ea, input logic la, input logic eb, input logic lb);
      @(negedge clk);
      enter_a = ea; leave_a = la; enter_b = eb; leave_b = lb;
      @(negedge clk);
      enter_a = 0; leave_a = 0; enter_b = 0; leave_b = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic step_tick();
      @(negedge clk);
      tick = 1'b1;
      ticks_given++;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic end_scn(input string r);
      repeat (3) @(negedge clk);
      chk({r, " pending expectations"}, sb_q.size(), 0);
      sb_q.delete();
   endtask

   initial begin
      restart(2'd3, 1'b0);
      chk("R1 reset count_a", count_a, 0);
      chk("R1 reset count_b", count_b, 0);
      chk("R10 reset switch_req", switch_req, 0);

      // R1: independent counts in idle phase
      repeat (3) pulse(1, 0, 0, 0);
      pulse(0, 0, 1, 0);
      chk("R1 count_a after 3 entries", count_a, 3);
      chk("R1 count_b after 1 entry", count_b, 1);
      pulse(1'b0, 1'b1, 1'b0, 1'b0);
      chk("R1 count_a after exit", count_a, 2);
      chk("R1 count_b untouched", count_b, 1);
      // R3: simultaneous entry and exit
      pulse(1, 1, 0, 0);
      chk("R3 count_a both pulses", count_a, 2);
      // R2: floor at zero
      pulse(0, 0, 0, 1);
      pulse(0, 0, 0, 1);
      chk("R2 count_b floor", count_b, 0);
      // R2: ceiling at 63
      repeat (70) pulse(1, 0, 0, 0);
      chk("R2 count_a ceiling", count_a, 63);
      // R11: idle never switches
      repeat (20) step_tick();
      end_scn("R11 idle");

      // R5: forced switch at max_a = 10 with traffic moving
      restart(2'd0, 1'b0);
      expect_sw("R5 green max", 10);
      for (int i = 0; i < 12; i++) begin
         pulse(1, 0, 0, 0);
         step_tick();
      end
      end_scn("R5");

      // R4: empty favoured queue still waits for min_a = 3
      restart(2'd0, 1'b0);
      expect_sw("R4 green min", 3);
      repeat (5) step_tick();
      end_scn("R4");

      // R6: f_a = 2*2+1-n_b drops to 0 when n_b reaches 5
      restart(2'd0, 1'b0);
      repeat (2) pulse(1, 0, 1, 0);
      repeat (4) step_tick();
      expect_sw("R6 control fn", 4);
      repeat (3) pulse(0, 0, 1, 0);
      chk("R6 count_b", count_b, 5);
      chk("R6 count_a", count_a, 2);
      end_scn("R6");

      // R7: favoured arm B stalls for 5 ticks
      restart(2'd0, 1'b1);
      repeat (3) pulse(0, 0, 1, 0);
      expect_sw("R7 stall", 5);
      repeat (6) step_tick();
      end_scn("R7");

      // R6: favoured arm B empties inside the window
      restart(2'd0, 1'b1);
      pulse(0, 0, 1, 0);
      repeat (3) step_tick();
      expect_sw("R6 empty queue", 3);
      pulse(0, 0, 0, 1);
      end_scn("R6 empty");

      // R8: left phase forced at max_left = 6
      restart(2'd1, 1'b0);
      expect_sw("R8 left max", 6);
      for (int i = 0; i < 8; i++) begin
         pulse(1, 0, 0, 0);
         step_tick();
      end
      end_scn("R8");

      // R9: pedestrian phase ends at max_ped = 4
      restart(2'd2, 1'b0);
      expect_sw("R9 ped", 4);
      repeat (6) step_tick();
      end_scn("R9");

      // R10: timer restarts after each request
      restart(2'd0, 1'b0);
      expect_sw("R10 repeat 1", 3);
      expect_sw("R10 repeat 2", 6);
      expect_sw("R10 repeat 3", 9);
      repeat (9) step_tick();
      end_scn("R10");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule